// File: doc/BRIEF.md
# Scan-Encoded Parent Pattern Sequencer

This block is the control and waveform section of a scan-based self-test pattern generator. Several deterministic parent vectors are not stored anywhere. They are carried by a single serial waveform bit. The waveform depends on how the current shift position relates to the current pattern number. Scan-cell ordering and inversion in the chains then turn that waveform into the intended parent vectors. A BIST controller drives five strobes. One pair loads and steps a shift counter. Another pair clears and advances a pattern counter. The fifth requests random child flipping.

The waveform bit is low only when the low select bits of the shift counter match the high select bits of the pattern counter. The high bits of the pattern counter therefore choose the parent. The lower bits count the patterns that belong to that parent. Each time the parent changes, the block suppresses child flipping for one complete scan load, so the new parent is applied exactly. It also pulses a flag when the parent changes and a separate flag when the whole pattern space has been covered. The scan chains, the pseudorandom source, the response compactor and the logic under test are outside this block.

Top module: `scan_parent_seq`

## Requirements
- R1: A load strobe sets the shift counter to CHAIN_LEN, the longest chain length. When load and step are asserted in the same cycle, the load wins.
- R2: Each step strobe lowers a nonzero shift counter by one. A step at zero is ignored. `shifting` is high exactly while the shift counter is nonzero, so a load gives exactly CHAIN_LEN step cycles of shifting.
- R3: `waveBit` is 0 when shift counter bits [SEL_W-1:0] equal pattern counter bits [PAT_W-1:PAT_W-SEL_W], and 1 otherwise. With SEL_W=2, the bit is 0 when (shift count mod 4) equals the parent index.
- R4: The pattern counter advances by one on each capture strobe. A clear strobe sets it to zero and takes priority over a capture in the same cycle. `parentSel` shows the top SEL_W bits of the pattern counter.
- R5: After reset, both counters are zero. `shifting`, `flipEn`, `parentChange`, `testDone` and `parentSel` are 0, and `waveBit` is 0.
- R6: `parentChange` is a one-cycle pulse in the cycle after a capture that changes the top SEL_W bits, excluding the wrap to zero. Each parent covers 2^(PAT_W-SEL_W) patterns.
- R7: `testDone` is a one-cycle pulse in the cycle after a capture that takes the pattern counter from all ones to zero. `parentChange` does not pulse then.
- R8: `flipEn` follows `childEn` while shifting. It is forced to 0 for the first complete load after reset, after a clear, and after any capture that changes the parent, including the wrap.
- R9: `flipEn` is 0 whenever the shift counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clrPat | input | 1 | Clear the pattern counter |
| incPat | input | 1 | Capture strobe; advance the pattern counter |
| loadShift | input | 1 | Load the shift counter with the chain length |
| decShift | input | 1 | Step the shift counter; one scan shift |
| childEn | input | 1 | Request random child flipping |
| waveBit | output | 1 | Serial waveform bit feeding the scan-in paths |
| flipEn | output | 1 | Gate for the random child flipping |
| shifting | output | 1 | Shift counter is nonzero |
| parentChange | output | 1 | One-cycle pulse when the parent changes |
| testDone | output | 1 | One-cycle pulse when the pattern counter wraps |
| parentSel | output | SEL_W | Index of the current parent |

## Verification
Every cycle, the bound checker checks the following:
- `flipEn` stays low outside shifting and never rises without `childEn`.
- A load always starts a shift.
- Shifting only ends after a step.
- The two pulses only follow a capture and never coincide.
- A clear always returns the parent index to zero.

Only the bench's scenarios can show that the waveform follows the shift-position rule for each parent. The same holds for the exact shift length after a simultaneous load and step. The scenarios also cover where the parent boundary and the wrap fall in the pattern sequence, and which load is held clean after a parent change or a clear.

// File: rtl/scan_parent_seq_pkg.sv
package scan_parent_seq_pkg;

  // Strobes from control to datapath, already resolved for priority
  typedef struct packed {
    logic loadShift;   // reload shift counter
    logic stepShift;   // decrement shift counter (nonzero only)
    logic clearPat;    // zero the pattern counter
    logic bumpPat;     // advance the pattern counter
  } seqStrobes_t;

  // Status from datapath back to control
  typedef struct packed {
    logic shiftZero;   // shift counter == 0
    logic shiftOne;    // shift counter == 1
    logic patMax;      // pattern counter all ones
    logic topBump;     // next increment changes the parent bits
  } seqStatus_t;

endpackage

// File: rtl/scan_parent_seq_dp.sv
module scan_parent_seq_dp
  import scan_parent_seq_pkg::*;
#(
  parameter int PAT_W     = 10,
  parameter int SEL_W     = 2,
  parameter int SHIFT_W   = 8,
  parameter int CHAIN_LEN = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strobes,
  output seqStatus_t       status,
  output logic             waveBit,
  output logic [SEL_W-1:0] parentSel
);

  localparam int LOW_W = PAT_W - SEL_W;
  localparam logic [SHIFT_W-1:0] LOAD_VAL = SHIFT_W'(CHAIN_LEN);

  logic [SHIFT_W-1:0] shiftCnt;
  logic [PAT_W-1:0]   patCnt;
  logic [SEL_W-1:0]   matchBits;

  // Shift counter: load has priority; stepping is pre-qualified by control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftCnt <= '0;
    end else if (strobes.loadShift) begin
      shiftCnt <= LOAD_VAL;
    end else if (strobes.stepShift) begin
      shiftCnt <= shiftCnt - 1'b1;
    end
  end

  // Pattern counter: clear has priority over increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patCnt <= '0;
    end else if (strobes.clearPat) begin
      patCnt <= '0;
    end else if (strobes.bumpPat) begin
      patCnt <= patCnt + 1'b1;
    end
  end

  // Bitwise comparator between shift position and parent index
  for (genvar i = 0; i < SEL_W; i++) begin : gCmp
    assign matchBits[i] = shiftCnt[i] ~^ patCnt[LOW_W + i];
  end

  assign waveBit   = ~&matchBits;
  assign parentSel = patCnt[PAT_W-1 -: SEL_W];

  always_comb begin
    status.shiftZero = (shiftCnt == '0);
    status.shiftOne  = (shiftCnt == SHIFT_W'(1));
    status.patMax    = &patCnt;
    status.topBump   = &patCnt[LOW_W-1:0];
  end

endmodule

// File: rtl/scan_parent_seq_ctrl.sv
module scan_parent_seq_ctrl
  import scan_parent_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clrPat,
  input  logic        incPat,
  input  logic        loadShift,
  input  logic        decShift,
  input  logic        childEn,
  input  seqStatus_t  status,
  output seqStrobes_t strobes,
  output logic        flipEn,
  output logic        shifting,
  output logic        parentChange,
  output logic        testDone
);

  logic holdParent;
  logic loadDone;
  logic parentMove;

  always_comb begin
    strobes.loadShift = loadShift;
    strobes.stepShift = decShift & ~loadShift & ~status.shiftZero;
    strobes.clearPat  = clrPat;
    strobes.bumpPat   = incPat & ~clrPat;
  end

  assign loadDone   = strobes.stepShift & status.shiftOne;
  assign parentMove = strobes.bumpPat & status.topBump;

  // A fresh parent is held clean until one full load completes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdParent <= 1'b1;
    end else if (strobes.clearPat || parentMove) begin
      holdParent <= 1'b1;
    end else if (loadDone) begin
      holdParent <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parentChange <= 1'b0;
      testDone     <= 1'b0;
    end else begin
      parentChange <= parentMove & ~status.patMax;
      testDone     <= strobes.bumpPat & status.patMax;
    end
  end

  assign shifting = ~status.shiftZero;
  assign flipEn   = childEn & ~holdParent & ~status.shiftZero;

endmodule

// File: rtl/scan_parent_seq.sv
module scan_parent_seq
  import scan_parent_seq_pkg::*;
#(
  parameter int PAT_W     = 10,
  parameter int SEL_W     = 2,
  parameter int SHIFT_W   = 8,
  parameter int CHAIN_LEN = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clrPat,
  input  logic             incPat,
  input  logic             loadShift,
  input  logic             decShift,
  input  logic             childEn,
  output logic             waveBit,
  output logic             flipEn,
  output logic             shifting,
  output logic             parentChange,
  output logic             testDone,
  output logic [SEL_W-1:0] parentSel
);

  seqStrobes_t strobes;
  seqStatus_t  status;

  scan_parent_seq_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .clrPat       (clrPat),
    .incPat       (incPat),
    .loadShift    (loadShift),
    .decShift     (decShift),
    .childEn      (childEn),
    .status       (status),
    .strobes      (strobes),
    .flipEn       (flipEn),
    .shifting     (shifting),
    .parentChange (parentChange),
    .testDone     (testDone)
  );

  scan_parent_seq_dp #(
    .PAT_W     (PAT_W),
    .SEL_W     (SEL_W),
    .SHIFT_W   (SHIFT_W),
    .CHAIN_LEN (CHAIN_LEN)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .status    (status),
    .waveBit   (waveBit),
    .parentSel (parentSel)
  );

endmodule

// File: rtl/scan_parent_seq_chk.sv
module scan_parent_seq_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             clrPat,
  input logic             incPat,
  input logic             loadShift,
  input logic             decShift,
  input logic             childEn,
  input logic             flipEn,
  input logic             shifting,
  input logic             parentChange,
  input logic             testDone,
  input logic [SEL_W-1:0] parentSel
);

  // R1
  load_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadShift |=> shifting);

  // R2
  shift_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shifting) |-> ($past(decShift) && !$past(loadShift)));

  // R4
  clear_parent_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrPat |=> (parentSel == '0));

  // R6
  change_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    parentChange |-> ($past(incPat) && !$past(clrPat)));

  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    testDone |-> ($past(incPat) && !$past(clrPat) && !parentChange));

  // R8
  flip_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    flipEn |-> childEn);

  // R9
  flip_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shifting |-> !flipEn);

endmodule

bind scan_parent_seq scan_parent_seq_chk #(.SEL_W(SEL_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .clrPat       (clrPat),
  .incPat       (incPat),
  .loadShift    (loadShift),
  .decShift     (decShift),
  .childEn      (childEn),
  .flipEn       (flipEn),
  .shifting     (shifting),
  .parentChange (parentChange),
  .testDone     (testDone),
  .parentSel    (parentSel)
);

// File: tb/scan_parent_seq_test.sv
module scan_parent_seq_test;

  localparam int PAT_W     = 6;
  localparam int SEL_W     = 2;
  localparam int SHIFT_W   = 5;
  localparam int CHAIN_LEN = 13;
  localparam int PER_PARENT = 1 << (PAT_W - SEL_W);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clrPat = 1'b0, incPat = 1'b0, loadShift = 1'b0, decShift = 1'b0, childEn = 1'b0;
  logic waveBit, flipEn, shifting, parentChange, testDone;
  logic [SEL_W-1:0] parentSel;

  int checks = 0;
  int errors = 0;
  int patModel = 0;

  always #2.5 clk = ~clk;

  scan_parent_seq #(
    .PAT_W(PAT_W), .SEL_W(SEL_W), .SHIFT_W(SHIFT_W), .CHAIN_LEN(CHAIN_LEN)
  ) uut (
    .clk(clk), .rstN(rstN), .clrPat(clrPat), .incPat(incPat),
    .loadShift(loadShift), .decShift(decShift), .childEn(childEn),
    .waveBit(waveBit), .flipEn(flipEn), .shifting(shifting),
    .parentChange(parentChange), .testDone(testDone), .parentSel(parentSel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // One capture strobe; checks pulses and parent index afterwards
  task automatic bump;
    int nxt;
    bit expChange, expDone;
    nxt = (patModel + 1) % (1 << PAT_W);
    expDone   = (nxt == 0);
    expChange = !expDone && ((nxt % PER_PARENT) == 0);
    incPat = 1'b1;
    tick();
    incPat = 1'b0;
    patModel = nxt;
    chk(parentChange == expChange, "R6 parentChange", parentChange, expChange);
    chk(testDone == expDone, "R7 testDone", testDone, expDone);
    chk(parentSel == patModel / PER_PARENT, "R4 parentSel", parentSel, patModel / PER_PARENT);
  endtask

  // Full scan load: waveform, shifting and flip gate at each step
  task automatic scanLoad(input bit expFlip);
    int p;
    p = patModel / PER_PARENT;
    loadShift = 1'b1;
    tick();
    loadShift = 1'b0;
    for (int m = CHAIN_LEN; m >= 1; m--) begin
      chk(shifting == 1'b1, "R2 shifting", shifting, 1);
      chk(waveBit == ((m % 4) != p), "R3 waveBit", waveBit, ((m % 4) != p));
      chk(flipEn == expFlip, "R8 flipEn", flipEn, expFlip);
      decShift = 1'b1;
      tick();
      decShift = 1'b0;
    end
    chk(shifting == 1'b0, "R2 shifting end", shifting, 0);
    chk(flipEn == 1'b0, "R9 flipEn idle", flipEn, 0);
  endtask

  task automatic testReset;
    chk(shifting == 0, "R5 shifting", shifting, 0);
    chk(flipEn == 0, "R5 flipEn", flipEn, 0);
    chk(parentChange == 0, "R5 parentChange", parentChange, 0);
    chk(testDone == 0, "R5 testDone", testDone, 0);
    chk(parentSel == 0, "R5 parentSel", parentSel, 0);
    chk(waveBit == 0, "R5 waveBit", waveBit, 0);
  endtask

  task automatic testFirstLoad;
    childEn = 1'b1;
    scanLoad(1'b0);            // R8 held after reset
    decShift = 1'b1;           // R2 step at zero ignored
    tick();
    decShift = 1'b0;
    chk(shifting == 0, "R2 dec at zero", shifting, 0);
    chk(waveBit == 0, "R2 count stays zero", waveBit, 0);
  endtask

  task automatic testChildren;
    bump();
    childEn = 1'b1;
    scanLoad(1'b1);            // R8 flipping allowed
    childEn = 1'b0;
    scanLoad(1'b0);            // R8 follows childEn
  endtask

  task automatic testLoadPriority;
    int n;
    loadShift = 1'b1;
    tick();
    loadShift = 1'b0;
    decShift = 1'b1;
    tick(); tick(); tick();
    loadShift = 1'b1;          // R1 load and step together
    tick();
    loadShift = 1'b0;
    n = 0;
    for (int g = 0; g < 100 && shifting; g++) begin
      tick();
      n++;
    end
    decShift = 1'b0;
    chk(n == CHAIN_LEN, "R1 load priority length", n, CHAIN_LEN);
  endtask

  task automatic testParentChange;
    while (patModel < PER_PARENT) bump();
    chk(parentSel == 1, "R6 parent one", parentSel, 1);
    childEn = 1'b1;
    scanLoad(1'b0);            // R8 new parent held clean
    scanLoad(1'b1);
    childEn = 1'b0;
  endtask

  task automatic testWrap;
    while (patModel != 0) bump();   // R7 pulse checked inside bump
    chk(parentSel == 0, "R7 back to parent 0", parentSel, 0);
    childEn = 1'b1;
    scanLoad(1'b0);            // R8 held after wrap
    childEn = 1'b0;
  endtask

  task automatic testClear;
    while (patModel < 2 * PER_PARENT + 3) bump();
    scanLoad(1'b0);            // R3 waveform for parent 2
    clrPat = 1'b1;
    incPat = 1'b1;             // R4 clear wins
    tick();
    clrPat = 1'b0;
    incPat = 1'b0;
    patModel = 0;
    chk(parentSel == 0, "R4 clear", parentSel, 0);
    chk(parentChange == 0, "R4 no pulse on clear", parentChange, 0);
    bump();
    childEn = 1'b1;
    scanLoad(1'b0);            // R8 held after clear
    scanLoad(1'b1);
    childEn = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstLoad();
    testChildren();
    testLoadPriority();
    testParentChange();
    testWrap();
    testClear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule